// File: doc/BRIEF.md
# Single-Step Shift and Rotate Unit

This block moves an N-bit operand one bit position left or right for a processor datapath. A 3-bit code picks one of eight operations: two logical shifts, two arithmetic shifts, two plain rotates and two rotates that pass through a carry flag. Each operation has its own rule for the bit that enters the vacated end. The bit that leaves the operand always becomes the carry-out.

The datapath itself is combinational. The top module registers its result and its carry flag. When `valid` is high on a clock edge, both registers take the new values. When `valid` is low, both registers hold their contents. A synchronous active-high reset clears both registers.

Top module: `shrot_unit`

## Requirements
- R1: On a clock edge with `rst` high, `result` becomes 0 and `carry_flag` becomes 0.
- R2: On an edge where `valid` is low, `result` and `carry_flag` keep their previous values.
- R3: Code 000 (logical right) gives `{1'b0, operand[W-1:1]}`.
- R4: Code 001 (logical left) and code 011 (arithmetic left) both give `{operand[W-2:0], 1'b0}`.
- R5: Code 010 (arithmetic right) gives `{operand[W-1], operand[W-1:1]}`, so the sign bit is kept.
- R6: Code 100 (rotate right) gives `{operand[0], operand[W-1:1]}`. Code 101 (rotate left) gives `{operand[W-2:0], operand[W-1]}`. No bit is lost.
- R7: Code 110 (rotate right through carry) gives `{carry_in, operand[W-1:1]}`. Code 111 (rotate left through carry) gives `{operand[W-2:0], carry_in}`.
- R8: For every code, the new carry flag is `operand[0]` when `op[0]` is 0 (right moves) and `operand[W-1]` when `op[0]` is 1 (left moves).
- R9: The values computed from the inputs sampled on an edge with `valid` high appear on `result` and `carry_flag` right after that edge, with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | Strobe that updates the result and carry registers |
| op | input | 3 | Operation code |
| operand | input | W | Value to shift or rotate |
| carry_in | input | 1 | Carry fed into the rotate-through-carry operations |
| result | output | W | Registered result |
| carry_flag | output | 1 | Registered carry-out |

## Verification
A wrong fill-bit selection shows up as a bad `result[W-1]` or `result[0]` in the cycle right after the strobe. A wrong carry selection shows up as a bad `carry_flag` at that same point. A faulty hold path changes the outputs on the first idle edge. So every fault appears one clock after the stimulus that exposes it. The stimulus covers all eight codes with operands whose two end bits differ, and gives `carry_in` both values.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  typedef enum logic [2:0] {
    OP_SRL = 3'b000,
    OP_SLL = 3'b001,
    OP_SRA = 3'b010,
    OP_SLA = 3'b011,
    OP_RRN = 3'b100,
    OP_RLN = 3'b101,
    OP_RRC = 3'b110,
    OP_RLC = 3'b111
  } shrot_op_e;

  // bit 0 of the code picks the direction: 1 moves left
  function automatic logic is_left(input shrot_op_e o);
    return o[0];
  endfunction
endpackage

// File: rtl/shrot_fill.sv
module shrot_fill
  import shrot_pkg::*;
(
  input  shrot_op_e op,
  input  logic      msb,
  input  logic      lsb,
  input  logic      cin,
  output logic      fill
);
  // bit entering the vacated end of the operand
  always_comb begin
    unique case (op)
      OP_SRL, OP_SLL, OP_SLA: fill = 1'b0;
      OP_SRA:                 fill = msb;
      OP_RRN:                 fill = lsb;
      OP_RLN:                 fill = msb;
      OP_RRC, OP_RLC:         fill = cin;
      default:                fill = 1'b0;
    endcase
  end
endmodule

// File: rtl/shrot_core.sv
module shrot_core
  import shrot_pkg::*;
#(
  parameter int W = 8
) (
  input  shrot_op_e      op,
  input  logic [W-1:0]   a,
  input  logic           cin,
  output logic [W-1:0]   y,
  output logic           cout
);
  localparam int TOP = W - 1;

  logic fill;
  logic left;
  logic [W-1:0] y_r;
  logic [W-1:0] y_l;

  shrot_fill u_fill (
    .op  (op),
    .msb (a[TOP]),
    .lsb (a[0]),
    .cin (cin),
    .fill(fill)
  );

  assign left = is_left(op);

  // one-position move network, built per bit
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == TOP) begin : g_top
      assign y_r[i] = fill;
    end else begin : g_rmid
      assign y_r[i] = a[i+1];
    end
    if (i == 0) begin : g_bot
      assign y_l[i] = fill;
    end else begin : g_lmid
      assign y_l[i] = a[i-1];
    end
  end

  assign y    = left ? y_l : y_r;
  assign cout = left ? a[TOP] : a[0];
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid,
  input  logic [2:0]   op,
  input  logic [W-1:0] operand,
  input  logic         carry_in,
  output logic [W-1:0] result,
  output logic         carry_flag
);
  logic [W-1:0] nxt_y;
  logic         nxt_c;

  shrot_core #(.W(W)) u_core (
    .op  (shrot_op_e'(op)),
    .a   (operand),
    .cin (carry_in),
    .y   (nxt_y),
    .cout(nxt_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result     <= '0;
      carry_flag <= 1'b0;
    end else if (valid) begin
      result     <= nxt_y;
      carry_flag <= nxt_c;
    end
  end
endmodule

// File: rtl/shrot_chk.sv
module shrot_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         valid,
  input logic [2:0]   op,
  input logic [W-1:0] operand,
  input logic         carry_in,
  input logic [W-1:0] result,
  input logic         carry_flag
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (result == '0 && carry_flag == 1'b0));

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !valid |=> ($stable(result) && $stable(carry_flag)));

  assert_srl_zero_fill_R3: assert property (@(posedge clk) disable iff (rst)
    (valid && op == 3'b000) |=> (result[W-1] == 1'b0 && result[W-2:0] == $past(operand[W-1:1])));

  assert_sra_sign_R5: assert property (@(posedge clk) disable iff (rst)
    (valid && op == 3'b010) |=> (result[W-1] == $past(operand[W-1])));

  assert_rotate_keeps_bits_R6: assert property (@(posedge clk) disable iff (rst)
    (valid && op[2:1] == 2'b10) |=> ($countones(result) == $countones($past(operand))));

  assert_rcr_carry_in_R7: assert property (@(posedge clk) disable iff (rst)
    (valid && op == 3'b110) |=> (result[W-1] == $past(carry_in)));

  assert_rcl_carry_in_R7: assert property (@(posedge clk) disable iff (rst)
    (valid && op == 3'b111) |=> (result[0] == $past(carry_in)));

  assert_carry_out_R8: assert property (@(posedge clk) disable iff (rst)
    valid |=> (carry_flag == ($past(op[0]) ? $past(operand[W-1]) : $past(operand[0]))));
endmodule

bind shrot_unit shrot_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .valid     (valid),
  .op        (op),
  .operand   (operand),
  .carry_in  (carry_in),
  .result    (result),
  .carry_flag(carry_flag)
);

// File: tb/sim_shrot_unit.sv
module sim_shrot_unit;
  localparam int W = 8;

  typedef struct {
    int           due;
    logic [W-1:0] y;
    logic         c;
    string        tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         valid = 1'b0;
  logic [2:0]   op = '0;
  logic [W-1:0] operand = '0;
  logic         carry_in = 1'b0;
  logic [W-1:0] result;
  logic         carry_flag;

  int    cyc = 0;
  int    errors = 0;
  int    checks = 0;
  item_t q[$];
  logic [W-1:0] m_y = '0;
  logic         m_c = 1'b0;

  shrot_unit #(.W(W)) u0 (
    .clk(clk), .rst(rst), .valid(valid), .op(op), .operand(operand),
    .carry_in(carry_in), .result(result), .carry_flag(carry_flag)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // independent reference model, written from the requirements
  task automatic model(input logic [2:0] o, input logic [W-1:0] a, input logic ci,
                       output logic [W-1:0] y, output logic c, output string tag);
    case (o)
      3'b000: begin y = {1'b0, a[W-1:1]};    tag = "R3"; end
      3'b001: begin y = {a[W-2:0], 1'b0};    tag = "R4"; end
      3'b010: begin y = {a[W-1], a[W-1:1]};  tag = "R5"; end
      3'b011: begin y = {a[W-2:0], 1'b0};    tag = "R4"; end
      3'b100: begin y = {a[0], a[W-1:1]};    tag = "R6"; end
      3'b101: begin y = {a[W-2:0], a[W-1]};  tag = "R6"; end
      3'b110: begin y = {ci, a[W-1:1]};      tag = "R7"; end
      default: begin y = {a[W-2:0], ci};     tag = "R7"; end
    endcase
    c = o[0] ? a[W-1] : a[0];
  endtask

  // driver: applies one cycle of stimulus and queues the expectation
  task automatic drive(input logic v, input logic [2:0] o, input logic [W-1:0] a, input logic ci);
    item_t it;
    string tg;
    @(posedge clk);
    #2;
    valid = v; op = o; operand = a; carry_in = ci;
    if (v) begin
      model(o, a, ci, m_y, m_c, tg);
      it.tag = {tg, "/R8/R9"};
    end else begin
      it.tag = "R2";
    end
    it.due = cyc + 1;
    it.y = m_y;
    it.c = m_c;
    q.push_back(it);
  endtask

  // monitor: compares at the falling edge after the capturing edge
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      check({it.tag, " result"}, result, it.y);
      check({it.tag, " carry"}, W'(carry_flag), W'(it.c));
    end
  end

  initial begin
    logic [W-1:0] pats [5] = '{8'h81, 8'h96, 8'h01, 8'h80, 8'h7E};
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 result", result, '0);
    check("R1 carry", W'(carry_flag), '0);
    #2 rst = 1'b0;
    for (int o = 0; o < 8; o++) begin
      for (int p = 0; p < 5; p++) begin
        drive(1'b1, 3'(o), pats[p], 1'(p & 1));
      end
      drive(1'b1, 3'(o), 8'hA5, 1'b1);
      drive(1'b1, 3'(o), 8'h5A, 1'b0);
    end
    // R2: idle cycles with changing inputs must not disturb outputs
    drive(1'b1, 3'b101, 8'hC3, 1'b0);
    drive(1'b0, 3'b000, 8'h00, 1'b1);
    drive(1'b0, 3'b110, 8'hFF, 1'b1);
    // R1: reset mid-run clears the registers
    drive(1'b1, 3'b111, 8'hFF, 1'b1);
    @(posedge clk);
    #2 rst = 1'b1; valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 result midrun", result, '0);
    check("R1 carry midrun", W'(carry_flag), '0);
    rst = 1'b0;
    repeat (2) @(posedge clk);
    if (q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R9: actual=%0d pending expected=0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule